// File: doc/BRIEF.md
# Software Write-Lock Command Monitor

This block sits beside the page buffer of an electrically erasable memory and watches every completed byte load (a strobe with a 17-bit address and an 8-bit data byte). It tracks a nonvolatile software write-lock bit. It recognises two keyed command sequences built from fixed address/data pairs. One is a three-load sequence that arms the lock. The other is a six-load sequence that arms the release. Each load is classified in the cycle it arrives. A load is either consumed as a command step, let through to the page buffer, or blocked.

While the lock is set, ordinary loads are dropped unless the three-load lock command came just before them. That command opens one page window of up to `PAGE_BYTES` loads. Neither command changes the lock bit at once. The pending change is applied on the end-of-programming pulse, whether or not any data followed the command. The lock bit is a register that takes the value on a preset input while reset is held. This models the state the cell held at power-down.

Top module: `sdp_cmd_monitor`

## Requirements
- R1: While reset is held, `prot_state` takes the value of `prot_preset`. With `ld_vld` low, `wr_allow` and `seq_consumed` are low.
- R2: The lock command is three loads in this order: data 0xAA at address 0x5555, data 0x55 at 0x2AAA, and data 0xA0 at 0x5555. Each matching load raises `seq_consumed` and keeps `wr_allow` low in the same cycle.
- R3: The release command is six loads in this order: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. Each matching load is consumed and is not passed on.
- R4: A load that is not the expected next step abandons the partial sequence. That same load is handled as an ordinary load (`seq_consumed` low). It is passed on when the lock is clear and blocked when the lock is set.
- R5: Command matching uses only address bits 14..0. Bits 16..15 may take any value.
- R6: While the lock is set and no page window is open, every ordinary load has `wr_allow` low.
- R7: After a lock command, the next `PAGE_BYTES` ordinary loads are passed on even while locked. The load after those is blocked.
- R8: A lock command sets `prot_state` one cycle after the next `prog_done` pulse, even with no data loads between. `prot_state` does not change before that pulse.
- R9: A release command clears `prot_state` one cycle after the next `prog_done` pulse. Until then, ordinary loads made while locked stay blocked.
- R10: `prog_done` closes the page window. A locked ordinary load after the pulse is blocked.
- R11: A `prog_done` with no pending command leaves `prot_state` unchanged. Only a completed command changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_preset | input | 1 | Lock value loaded while reset is held (stored cell state) |
| ld_vld | input | 1 | Completed byte-load strobe, one cycle per load |
| ld_addr | input | 17 | Address of the load |
| ld_data | input | 8 | Data of the load |
| prog_done | input | 1 | End-of-programming pulse |
| wr_allow | output | 1 | Current load may enter the page buffer |
| prot_state | output | 1 | Software write-lock state |
| seq_consumed | output | 1 | Current load was taken as a command step |

## Verification
The hardest state to reach is a full page window while locked, followed by one more load. Getting there takes a lock command, then exactly `PAGE_BYTES` ordinary loads with no `prog_done` in between, and then the extra load, which must be blocked. The bench builds this run directly and follows it with a `prog_done` and one more load, to show that the window has closed. A second difficult path is the release command broken off at its fifth step. The broken-off load must then be treated as an ordinary write while the lock is still set. A reference model follows every load cycle by cycle so that both paths are checked on each clock.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  localparam int CMD_AW = 15;

  localparam logic [CMD_AW-1:0] KEY_ADDR_HI = 15'h5555;
  localparam logic [CMD_AW-1:0] KEY_ADDR_LO = 15'h2AAA;

  localparam logic [7:0] KEY_OPEN   = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] KEY_LOCK   = 8'hA0;
  localparam logic [7:0] KEY_ESC    = 8'h80;
  localparam logic [7:0] KEY_FREE   = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_R3,
    ST_R4,
    ST_R5
  } seq_st_e;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_LOCK,
    PEND_FREE
  } pend_e;

  function automatic logic key_hit(input logic [CMD_AW-1:0] a,
                                   input logic [7:0]        d,
                                   input logic [CMD_AW-1:0] ea,
                                   input logic [7:0]        ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic logic room_left(input int unsigned used,
                                     input int unsigned cap);
    return used < cap;
  endfunction

endpackage

// File: rtl/sdp_seq_matcher.sv
module sdp_seq_matcher
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_vld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              step_hit,
  output logic              lock_done,
  output logic              free_done
);

  seq_st_e             st_q, st_d;
  logic [CMD_AW-1:0]   ca;
  logic [7:0]          cd;
  logic                hit;

  assign ca = ld_addr[CMD_AW-1:0];
  assign cd = ld_data[7:0];

  always_comb begin
    hit       = 1'b0;
    st_d      = st_q;
    lock_done = 1'b0;
    free_done = 1'b0;
    unique case (st_q)
      ST_IDLE: if (key_hit(ca, cd, KEY_ADDR_HI, KEY_OPEN)) begin
        hit = 1'b1; st_d = ST_K1;
      end
      ST_K1: if (key_hit(ca, cd, KEY_ADDR_LO, KEY_SECOND)) begin
        hit = 1'b1; st_d = ST_K2;
      end
      ST_K2: begin
        if (key_hit(ca, cd, KEY_ADDR_HI, KEY_LOCK)) begin
          hit = 1'b1; st_d = ST_IDLE; lock_done = ld_vld;
        end else if (key_hit(ca, cd, KEY_ADDR_HI, KEY_ESC)) begin
          hit = 1'b1; st_d = ST_R3;
        end
      end
      ST_R3: if (key_hit(ca, cd, KEY_ADDR_HI, KEY_OPEN)) begin
        hit = 1'b1; st_d = ST_R4;
      end
      ST_R4: if (key_hit(ca, cd, KEY_ADDR_LO, KEY_SECOND)) begin
        hit = 1'b1; st_d = ST_R5;
      end
      ST_R5: if (key_hit(ca, cd, KEY_ADDR_HI, KEY_FREE)) begin
        hit = 1'b1; st_d = ST_IDLE; free_done = ld_vld;
      end
      default: st_d = ST_IDLE;
    endcase
    if (!hit) st_d = ST_IDLE;
  end

  assign step_hit = ld_vld && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= ST_IDLE;
    else if (ld_vld) st_q <= st_d;
  end

endmodule

// File: rtl/sdp_page_window.sv
module sdp_page_window
  import sdp_pkg::*;
#(
  parameter int PAGE_BYTES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic close_req,
  input  logic take,
  output logic win_open,
  output logic win_room
);

  localparam int CNT_W = $clog2(PAGE_BYTES + 1);

  logic [CNT_W-1:0] used_q;
  logic             open_q;

  assign win_open = open_q;
  assign win_room = room_left(int'(used_q), PAGE_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      used_q <= '0;
    end else if (open_req) begin
      open_q <= 1'b1;
      used_q <= '0;
    end else if (close_req) begin
      open_q <= 1'b0;
      used_q <= '0;
    end else if (open_q && take && win_room) begin
      used_q <= used_q + 1'b1;
    end
  end

endmodule

// File: rtl/sdp_prot_reg.sv
module sdp_prot_reg
  import sdp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic preset,
  input  logic arm_lock,
  input  logic arm_free,
  input  logic prog_done,
  output logic prot
);

  pend_e pend_q;
  logic  prot_q;

  assign prot = prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= PEND_NONE;
    else if (arm_lock)   pend_q <= PEND_LOCK;
    else if (arm_free)   pend_q <= PEND_FREE;
    else if (prog_done)  pend_q <= PEND_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= preset;
    end else if (prog_done) begin
      if (pend_q == PEND_LOCK)      prot_q <= 1'b1;
      else if (pend_q == PEND_FREE) prot_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sdp_cmd_monitor.sv
module sdp_cmd_monitor
  import sdp_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_preset,
  input  logic              ld_vld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              prog_done,
  output logic              wr_allow,
  output logic              prot_state,
  output logic              seq_consumed
);

  logic step_hit;
  logic lock_done;
  logic free_done;
  logic win_open;
  logic win_room;
  logic plain_ld;

  sdp_seq_matcher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_vld    (ld_vld),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .step_hit  (step_hit),
    .lock_done (lock_done),
    .free_done (free_done)
  );

  sdp_page_window #(.PAGE_BYTES(PAGE_BYTES)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_req  (lock_done),
    .close_req (prog_done),
    .take      (wr_allow),
    .win_open  (win_open),
    .win_room  (win_room)
  );

  sdp_prot_reg u_prot (
    .clk       (clk),
    .rst_n     (rst_n),
    .preset    (prot_preset),
    .arm_lock  (lock_done),
    .arm_free  (free_done),
    .prog_done (prog_done),
    .prot      (prot_state)
  );

  assign plain_ld     = ld_vld && !step_hit;
  assign seq_consumed = step_hit;
  assign wr_allow     = plain_ld && (!prot_state || (win_open && win_room));

endmodule

// File: rtl/sdp_cmd_monitor_chk.sv
module sdp_cmd_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_vld,
  input logic prog_done,
  input logic wr_allow,
  input logic seq_consumed,
  input logic prot_state,
  input logic win_open,
  input logic win_room,
  input logic lock_done,
  input logic free_done
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_vld |-> (!wr_allow && !seq_consumed));

  p_step_not_passed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_consumed |-> !wr_allow);

  p_single_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lock_done, free_done}));

  p_locked_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && prot_state && !win_open) |-> !wr_allow);

  p_page_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && prot_state && win_open && !win_room) |-> !wr_allow);

  p_change_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_state) |-> $past(prog_done));

  p_window_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done && !lock_done) |=> !win_open);

endmodule

bind sdp_cmd_monitor sdp_cmd_monitor_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ld_vld       (ld_vld),
  .prog_done    (prog_done),
  .wr_allow     (wr_allow),
  .seq_consumed (seq_consumed),
  .prot_state   (prot_state),
  .win_open     (win_open),
  .win_room     (win_room),
  .lock_done    (lock_done),
  .free_done    (free_done)
);

// File: tb/test_sdp_cmd_monitor.sv
module test_sdp_cmd_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int PAGE       = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_preset = 1'b0;
  logic        ld_vld = 1'b0;
  logic [16:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic        prog_done = 1'b0;
  logic        wr_allow, prot_state, seq_consumed;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  int m_prot = 0;
  int m_pos  = 0;   // keys matched so far in the current sequence
  int m_pend = 0;   // 0 none, 1 lock, 2 release
  int m_win  = 0;
  int m_used = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdp_cmd_monitor i_sdp_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .prot_preset(prot_preset),
    .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_data(ld_data),
    .prog_done(prog_done), .wr_allow(wr_allow),
    .prot_state(prot_state), .seq_consumed(seq_consumed)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // which key (address, data) is wanted next; pos 2 accepts two keys
  function automatic int key_match(input int pos, input logic [16:0] a, input logic [7:0] d,
                                   output int done);
    int lo;
    lo   = int'(a & 17'h7FFF);
    done = 0;
    case (pos)
      0: return (lo == 'h5555 && d == 8'hAA);
      1: return (lo == 'h2AAA && d == 8'h55);
      2: begin
           if (lo == 'h5555 && d == 8'hA0) begin done = 1; return 1; end
           return (lo == 'h5555 && d == 8'h80);
         end
      3: return (lo == 'h5555 && d == 8'hAA);
      4: return (lo == 'h2AAA && d == 8'h55);
      5: begin
           if (lo == 'h5555 && d == 8'h20) begin done = 2; return 1; end
           return 0;
         end
      default: return 0;
    endcase
  endfunction

  task automatic cyc(input bit v, input logic [16:0] a, input logic [7:0] d,
                     input bit pd, input string tag);
    int hit, done, allow;
    ld_vld = v; ld_addr = a; ld_data = d; prog_done = pd;
    #1;
    hit   = v ? key_match(m_pos, a, d, done) : 0;
    if (!v) done = 0;
    allow = v && !hit && (m_prot == 0 || (m_win != 0 && m_used < PAGE));
    check(tag, "seq_consumed", int'(seq_consumed), hit);
    check(tag, "wr_allow",     int'(wr_allow),     allow);
    check(tag, "prot_state",   int'(prot_state),   m_prot);
    @(posedge clk);
    if (pd) begin
      if (m_pend == 1) m_prot = 1;
      if (m_pend == 2) m_prot = 0;
    end
    if (done == 1) begin m_pend = 1; m_win = 1; m_used = 0; end
    else if (done == 2) m_pend = 2;
    else if (pd) begin m_pend = 0; m_win = 0; m_used = 0; end
    else if (allow && m_win != 0 && m_used < PAGE) m_used++;
    if (v) begin
      if (hit && done == 0) m_pos = (m_pos == 2 && !(d == 8'hA0)) ? 3 : m_pos + 1;
      else m_pos = 0;
    end
    @(negedge clk);
    ld_vld = 1'b0; prog_done = 1'b0;
  endtask

  task automatic do_reset(input bit pre);
    @(negedge clk);
    rst_n = 1'b0; prot_preset = pre;
    ld_vld = 1'b0; prog_done = 1'b0;
    repeat (2) @(negedge clk);
    m_prot = pre; m_pos = 0; m_pend = 0; m_win = 0; m_used = 0;
    rst_n = 1'b1;
  endtask

  task automatic lock_cmd(input string tag);
    cyc(1, 17'h05555, 8'hAA, 0, tag);
    cyc(1, 17'h02AAA, 8'h55, 0, tag);
    cyc(1, 17'h05555, 8'hA0, 0, tag);
  endtask

  task automatic free_cmd(input string tag);
    cyc(1, 17'h05555, 8'hAA, 0, tag);
    cyc(1, 17'h02AAA, 8'h55, 0, tag);
    cyc(1, 17'h05555, 8'h80, 0, tag);
    cyc(1, 17'h05555, 8'hAA, 0, tag);
    cyc(1, 17'h02AAA, 8'h55, 0, tag);
    cyc(1, 17'h05555, 8'h20, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: reset with preset clear, then idle
    do_reset(1'b0);
    cyc(0, 0, 0, 0, "R1");
    // R4: ordinary load passes while unlocked
    cyc(1, 17'h00100, 8'h12, 0, "R4");
    // R2: lock command then three data bytes, then end of programming
    lock_cmd("R2");
    for (int i = 0; i < 3; i++) cyc(1, 17'h00200 + 17'(i), 8'(i), 0, "R7");
    cyc(0, 0, 0, 1, "R8");
    cyc(0, 0, 0, 0, "R8");
    // R6: locked ordinary load blocked
    cyc(1, 17'h00300, 8'h33, 0, "R6");
    // R5: upper address bits ignored, then R4 mismatch aborts
    cyc(1, 17'h1D555, 8'hAA, 0, "R5");
    cyc(1, 17'h02AAA, 8'h56, 0, "R4");
    cyc(1, 17'h02AAA, 8'h55, 0, "R4");
    // R7: full page while locked, one extra load blocked
    lock_cmd("R2");
    for (int i = 0; i < PAGE; i++) cyc(1, 17'h00400 + 17'(i), 8'(i ^ 8'h5A), 0, "R7");
    cyc(1, 17'h00500, 8'h01, 0, "R7");
    // R10: window closes at end of programming
    cyc(0, 0, 0, 1, "R10");
    cyc(1, 17'h00501, 8'h02, 0, "R10");
    // R4: release broken at fifth key, load treated as ordinary (blocked)
    cyc(1, 17'h05555, 8'hAA, 0, "R3");
    cyc(1, 17'h02AAA, 8'h55, 0, "R3");
    cyc(1, 17'h05555, 8'h80, 0, "R3");
    cyc(1, 17'h05555, 8'hAA, 0, "R3");
    cyc(1, 17'h02AAA, 8'h77, 0, "R4");
    cyc(1, 17'h05555, 8'h20, 0, "R4");
    // R3 and R9: full release, still locked until end of programming
    free_cmd("R3");
    cyc(1, 17'h00600, 8'h44, 0, "R9");
    cyc(0, 0, 0, 1, "R9");
    cyc(0, 0, 0, 0, "R9");
    cyc(1, 17'h00601, 8'h45, 0, "R9");
    // R8: lock command with no data still locks at end of programming
    lock_cmd("R8");
    cyc(0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 1, "R8");
    cyc(1, 17'h00700, 8'h46, 0, "R8");
    // R11: end of programming without a command changes nothing
    cyc(0, 0, 0, 1, "R11");
    cyc(0, 0, 0, 0, "R11");
    // R11: preset restores the stored state across reset
    do_reset(1'b1);
    cyc(0, 0, 0, 0, "R11");
    cyc(1, 17'h00800, 8'h47, 0, "R11");
    do_reset(1'b0);
    cyc(0, 0, 0, 0, "R1");
    cyc(1, 17'h00801, 8'h48, 0, "R1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule